// File: doc/BRIEF.md
# Eight-digit multiplexed display scanner

This block takes an eight-digit BCD value held elsewhere and drives a time-multiplexed seven-segment display from it. At any time one digit position is active. The scan starts at the most significant position and steps down to the least significant, then starts again. Each digit slot begins with a short lead interval, then a drive window, then a blanking gap. During the lead interval the BCD bus already carries the value of the new digit, but no strobe is on. This lets external logic latch the BCD data on the leading edge of the strobe. The blanking gap at the end of the slot stops the previous digit from showing faintly on the next one.

The segment path adds several display-only rules. Leading zeros are blanked, but blanking stops at the decimal-point position and is turned off when the value has overflowed. Overflow is shown on the decimal point of the top digit. A test flag lights every segment and every decimal point. An off flag darkens all strobes and segments, and it wins over the test flag. The BCD bus is never affected by any of these rules.

The scan rate is set by the slot length in clock cycles. With a 10 MHz clock, a 2500-cycle slot gives a 500 Hz frame. The current digit index is also brought out as a phase signal, so that a neighbouring input decoder can tell which digit line is live.

Top module: `dispScan`

## Requirements
- R1: After reset the scan visits the digit indices 7, 6, 5, 4, 3, 2, 1, 0 in that order and then repeats. Index 7 is the most significant digit and index 0 the least. Each index is held for exactly SLOT_CYCLES clock cycles.
- R2: Inside a slot, counting the slot's cycles from 0, the strobe of the current digit is on only in cycles LEAD_CYCLES through SLOT_CYCLES-BLANK_CYCLES-1. At most one strobe bit is on at any time. Strobe bit i drives digit index i.
- R3: `bcdOut` carries the value of the current digit, taken from `digitsIn[4*i+3:4*i]`, for the whole slot, including the lead cycles before the strobe comes on. It is not changed by blanking, test or off.
- R4: While a digit is driven, `seg` shows it with bit 0 = a through bit 6 = g, active high: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex). A nibble value of 10 to 15 shows all segments off. Outside the drive window `seg` and `segDp` are 0.
- R5: A digit at index i is blanked (segments off) when i > `dpPos` and every digit from index i up to index 7 is zero. Digits at or right of `dpPos`, and zeros below a non-zero digit, are shown.
- R6: When `overflow` is 1, no digit is blanked.
- R7: `segDp` is on while the digit at index `dpPos` is driven.
- R8: When `overflow` is 1, `segDp` is also on while digit index 7 is driven.
- R9: When `dispTest` is 1 and `dispOff` is 0, every driven digit shows `seg`=7F with `segDp`=1.
- R10: When `dispOff` is 1, `strobe`, `seg` and `segDp` are 0 from the next cycle onward, whatever `dispTest` is.
- R11: While `rstN` is low, `strobe`, `seg`, `segDp` and `bcdOut` are 0 and `digitSel` is 7.
- R12: `digitSel` gives the index of the digit whose slot is current. Any strobe that is on is bit `digitSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Active-low synchronous reset |
| digitsIn | input | 32 | Eight BCD digits, index 0 in bits 3:0 |
| dpPos | input | 3 | Index of the digit that carries the decimal point |
| overflow | input | 1 | Measured value overflowed |
| dispTest | input | 1 | Light all segments and decimal points |
| dispOff | input | 1 | Darken strobes and segments |
| strobe | output | 8 | One-hot digit strobes, bit i for index i |
| seg | output | 7 | Segments a (bit 0) to g (bit 6) |
| segDp | output | 1 | Decimal-point segment |
| bcdOut | output | 4 | BCD value of the current digit |
| digitSel | output | 3 | Index of the current digit slot |

## Verification
Some properties are checked on every cycle: the strobe stays one-hot and matches `digitSel`, segments are lit only inside a strobe window, the digit index only steps downward with wrap-around, and the off flag darkens everything one cycle after it is seen. The rules that depend on data need the bench's scenarios to show them. These are the exact segment patterns, where leading-zero blanking starts and stops relative to the decimal point and the overflow flag, and the BCD value leading the strobe. The bench drives directed digit strings and random values, then compares every output on every cycle against its own model of the slot timing.

// File: rtl/scanPkg.sv
package scanPkg;
  localparam int unsigned DIGIT_COUNT = 8;
  localparam int unsigned IDX_W = $clog2(DIGIT_COUNT);

  // Control strobes from timing to datapath
  typedef struct packed {
    logic [IDX_W-1:0] idx;    // digit index of the current slot
    logic             drive;  // inside the drive window of the slot
  } ctlStrobe_t;
endpackage

// File: rtl/scanCtl.sv
module scanCtl
  import scanPkg::*;
#(
  parameter int unsigned SLOT_CYCLES  = 2500,
  parameter int unsigned LEAD_CYCLES  = 40,
  parameter int unsigned BLANK_CYCLES = 60
) (
  input  logic       clk,
  input  logic       rstN,
  output ctlStrobe_t ctl
);
  localparam int unsigned TICK_W = $clog2(SLOT_CYCLES);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_CYCLES - 1);
  localparam logic [TICK_W-1:0] DRIVE_ON  = TICK_W'(LEAD_CYCLES);
  localparam logic [TICK_W-1:0] DRIVE_OFF = TICK_W'(SLOT_CYCLES - BLANK_CYCLES);
  localparam logic [IDX_W-1:0]  IDX_TOP   = IDX_W'(DIGIT_COUNT - 1);

  logic [TICK_W-1:0] tick;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick <= '0;
      idx  <= IDX_TOP;
    end else if (tick == TICK_LAST) begin
      tick <= '0;
      idx  <= (idx == '0) ? IDX_TOP : idx - 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_comb begin
    ctl.idx   = idx;
    ctl.drive = (tick >= DRIVE_ON) && (tick < DRIVE_OFF);
  end
endmodule

// File: rtl/scanData.sv
module scanData
  import scanPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               ctl,
  input  logic [DIGIT_COUNT*4-1:0] digitsIn,
  input  logic [IDX_W-1:0]         dpPos,
  input  logic                     overflow,
  input  logic                     dispTest,
  input  logic                     dispOff,
  output logic [DIGIT_COUNT-1:0]   strobe,
  output logic [6:0]               seg,
  output logic                     segDp,
  output logic [3:0]               bcdOut,
  output logic [IDX_W-1:0]         digitSel
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DIGIT_COUNT - 1);

  function automatic logic [6:0] toSeg(input logic [3:0] v);
    case (v)
      4'd0: toSeg = 7'h3F;
      4'd1: toSeg = 7'h06;
      4'd2: toSeg = 7'h5B;
      4'd3: toSeg = 7'h4F;
      4'd4: toSeg = 7'h66;
      4'd5: toSeg = 7'h6D;
      4'd6: toSeg = 7'h7D;
      4'd7: toSeg = 7'h07;
      4'd8: toSeg = 7'h7F;
      4'd9: toSeg = 7'h6F;
      default: toSeg = 7'h00;
    endcase
  endfunction

  // zeroFrom[i]: digits i..top are all zero
  logic [DIGIT_COUNT:0] zeroFrom;
  assign zeroFrom[DIGIT_COUNT] = 1'b1;
  for (genvar i = 0; i < DIGIT_COUNT; i++) begin : gZero
    assign zeroFrom[i] = (digitsIn[i*4 +: 4] == 4'd0) && zeroFrom[i+1];
  end

  logic [3:0] curDigit;
  logic       blankNow;
  logic       dpNow;
  logic       lit;
  assign curDigit = digitsIn[ctl.idx*4 +: 4];
  assign blankNow = !overflow && (ctl.idx > dpPos) && zeroFrom[ctl.idx];
  assign dpNow    = (ctl.idx == dpPos) || (overflow && ctl.idx == IDX_TOP);
  assign lit      = ctl.drive && !dispOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobe   <= '0;
      seg      <= '0;
      segDp    <= 1'b0;
      bcdOut   <= '0;
      digitSel <= IDX_TOP;
    end else begin
      bcdOut   <= curDigit;
      digitSel <= ctl.idx;
      strobe   <= lit ? (DIGIT_COUNT'(1) << ctl.idx) : '0;
      if (!lit) begin
        seg   <= '0;
        segDp <= 1'b0;
      end else if (dispTest) begin
        seg   <= 7'h7F;
        segDp <= 1'b1;
      end else begin
        seg   <= blankNow ? 7'h00 : toSeg(curDigit);
        segDp <= dpNow;
      end
    end
  end
endmodule

// File: rtl/dispScan.sv
module dispScan
  import scanPkg::*;
#(
  parameter int unsigned SLOT_CYCLES  = 2500,
  parameter int unsigned LEAD_CYCLES  = 40,
  parameter int unsigned BLANK_CYCLES = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] digitsIn,
  input  logic [2:0]  dpPos,
  input  logic        overflow,
  input  logic        dispTest,
  input  logic        dispOff,
  output logic [7:0]  strobe,
  output logic [6:0]  seg,
  output logic        segDp,
  output logic [3:0]  bcdOut,
  output logic [2:0]  digitSel
);
  ctlStrobe_t ctl;

  scanCtl #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .LEAD_CYCLES (LEAD_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) uCtl (
    .clk (clk),
    .rstN(rstN),
    .ctl (ctl)
  );

  scanData uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .digitsIn(digitsIn),
    .dpPos   (dpPos),
    .overflow(overflow),
    .dispTest(dispTest),
    .dispOff (dispOff),
    .strobe  (strobe),
    .seg     (seg),
    .segDp   (segDp),
    .bcdOut  (bcdOut),
    .digitSel(digitSel)
  );
endmodule

// File: rtl/dispScanChk.sv
module dispScanChk (
  input logic       clk,
  input logic       rstN,
  input logic       dispOff,
  input logic [7:0] strobe,
  input logic [6:0] seg,
  input logic       segDp,
  input logic [2:0] digitSel
);
  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R12
  strobe_matches_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != 8'd0) |-> (strobe == (8'd1 << digitSel)));

  // R4
  seg_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((seg != 7'd0) || segDp) |-> (strobe != 8'd0));

  // R1
  scan_downward_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel != $past(digitSel)) |-> (digitSel == $past(digitSel) - 3'd1));

  // R10
  off_darkens_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispOff |=> (strobe == 8'd0 && seg == 7'd0 && !segDp));
endmodule

bind dispScan dispScanChk chk (.*);

// File: tb/dispScan_test.sv
module dispScan_test;
  localparam int SLOT  = 12;
  localparam int LEAD  = 2;
  localparam int BLANK = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] digitsIn = '0;
  logic [2:0]  dpPos = '0;
  logic        overflow = 1'b0;
  logic        dispTest = 1'b0;
  logic        dispOff = 1'b0;
  logic [7:0]  strobe;
  logic [6:0]  seg;
  logic        segDp;
  logic [3:0]  bcdOut;
  logic [2:0]  digitSel;

  int total = 0;
  int bad = 0;
  int kCnt = 0;

  always #10 clk = ~clk;

  dispScan #(.SLOT_CYCLES(SLOT), .LEAD_CYCLES(LEAD), .BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rstN(rstN), .digitsIn(digitsIn), .dpPos(dpPos),
    .overflow(overflow), .dispTest(dispTest), .dispOff(dispOff),
    .strobe(strobe), .seg(seg), .segDp(segDp), .bcdOut(bcdOut),
    .digitSel(digitSel)
  );

  function automatic logic [6:0] expSeg(input logic [3:0] v);
    logic [6:0] pat [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 4'd10) ? pat[v] : 7'h00;
  endfunction

  function automatic bit expBlank(input int i);
    if (overflow || i <= int'(dpPos)) return 1'b0;
    for (int j = i; j < 8; j++)
      if (digitsIn[j*4 +: 4] != 4'd0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got %0h expected %0h (cycle %0d)", tag, what, got, exp, kCnt);
    end
  endtask

  task automatic checkCycle(input string tag);
    int tick = (kCnt - 1) % SLOT;
    int idx = 7 - (((kCnt - 1) / SLOT) % 8);
    bit drive = (tick >= LEAD) && (tick < SLOT - BLANK);
    bit lit = drive && !dispOff;
    logic [3:0] d = digitsIn[idx*4 +: 4];
    int eStrobe = lit ? (1 << idx) : 0;
    int eSeg, eDp;
    if (!lit) begin eSeg = 0; eDp = 0; end
    else if (dispTest) begin eSeg = 'h7F; eDp = 1; end
    else begin
      eSeg = expBlank(idx) ? 0 : int'(expSeg(d));
      eDp = (idx == int'(dpPos)) || (overflow && idx == 7);
    end
    cmp("R1 R12", "digitSel", int'(digitSel), idx);
    cmp("R2", "strobe", int'(strobe), eStrobe);
    cmp("R3", "bcdOut", int'(bcdOut), int'(d));
    cmp(tag, "seg", int'(seg), eSeg);
    cmp(tag, "segDp", int'(segDp), eDp);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    kCnt++;
    @(negedge clk);
    checkCycle(tag);
  endtask

  task automatic runScan(input string tag);
    repeat (8 * SLOT) step(tag);
  endtask

  task automatic setIn(input logic [31:0] d, input logic [2:0] p,
                       input logic ov, input logic t, input logic o);
    digitsIn = d; dpPos = p; overflow = ov; dispTest = t; dispOff = o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    cmp("R11", "strobe", int'(strobe), 0);
    cmp("R11", "seg", int'(seg), 0);
    cmp("R11", "segDp", int'(segDp), 0);
    cmp("R11", "bcdOut", int'(bcdOut), 0);
    cmp("R11", "digitSel", int'(digitSel), 7);
    rstN = 1'b1;

    // R4 every digit value, no blanking (point on top digit)
    setIn(32'h89012345, 3'd7, 1'b0, 1'b0, 1'b0); runScan("R4");
    setIn(32'h76543210, 3'd7, 1'b0, 1'b0, 1'b0); runScan("R4");
    setIn(32'h00AB00F0, 3'd7, 1'b0, 1'b0, 1'b0); runScan("R4");
    // R5 leading-zero blanking up to the point
    setIn(32'h00012345, 3'd0, 1'b0, 1'b0, 1'b0); runScan("R5");
    setIn(32'h00000000, 3'd2, 1'b0, 1'b0, 1'b0); runScan("R5");
    setIn(32'h00100000, 3'd0, 1'b0, 1'b0, 1'b0); runScan("R5");
    // R7 point positions
    setIn(32'h00000123, 3'd4, 1'b0, 1'b0, 1'b0); runScan("R7");
    // R6 and R8 overflow
    setIn(32'h00012345, 3'd0, 1'b1, 1'b0, 1'b0); runScan("R6 R8");
    setIn(32'h00000000, 3'd3, 1'b1, 1'b0, 1'b0); runScan("R6 R8");
    // R9 display test
    setIn(32'h00000000, 3'd0, 1'b0, 1'b1, 1'b0); runScan("R9");
    // R10 off, alone and with test
    setIn(32'h12345678, 3'd1, 1'b1, 1'b0, 1'b1); runScan("R10");
    setIn(32'h12345678, 3'd1, 1'b0, 1'b1, 1'b1); runScan("R10");

    // random values, flags changing mid-scan
    for (int n = 0; n < 40; n++) begin
      logic [31:0] d = '0;
      int lead = $urandom % 9;
      for (int j = 0; j < 8; j++)
        d[j*4 +: 4] = (j >= 8 - lead) ? 4'd0 : 4'($urandom % 10);
      setIn(d, 3'($urandom % 8), ($urandom % 5) == 0,
            ($urandom % 8) == 0, ($urandom % 8) == 0);
      repeat (2 * SLOT + int'($urandom % (3 * SLOT))) step("R5");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule